// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital side of a two-channel, 12-bit digital-to-analog converter. A host sends 16-bit command words over a three-wire serial link: an active-low select, a serial clock and a data line. Each word carries a 4-bit control field in its top bits and a 12-bit payload below it, and the word is sent MSB first. Both channels keep two registers in series: a staging register that commands fill, and an output register that drives the converter. The output registers change only on an explicit transfer command, so both channels can be made to move together.

The shift register that collects the words also drives a serial output. This output can feed the next device in a chain, or the host can use it to read back what it sent. A command picks the clock edge on which this output changes. The block also drives one general-purpose logic level that the host sets by command, and it supports a software shutdown state. An active-low lockout input vetoes shutdown commands. When the lockout input falls during shutdown, it brings the block out of shutdown with the previous output codes intact. All serial and lockout inputs are brought into the system clock domain through synchronizers, and everything else runs on that clock.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After a synchronous reset, both output codes are zero, `shutdown` is 0, `aux_out` is 0, `ser_out` is 0, and the serial output uses the falling-edge timing of R7.
- R2: A word is decoded on the rising edge of `ser_sel_n` only if exactly 16 rising `ser_clk` edges arrived while `ser_sel_n` was low. Frames of 15, 17 or 32 clocks leave every output except `ser_out` unchanged.
- R3: Control 0x1 loads payload bits [11:0] into staging register A, and control 0x2 loads them into staging register B. Neither changes `code_a` or `code_b`.
- R4: Control 0x3 loads the payload into both staging registers and, in the same step, moves it to both output codes.
- R5: Control 0x8 copies both staging registers to the output codes.
- R6: Control 0x9 sets `aux_out` to payload bit 0. No other control code changes `aux_out`.
- R7: In falling-edge timing (selected by control 0xB), `ser_out` changes after each falling `ser_clk` edge. It shows the bit that was sampled 16 rising edges before the next rising edge.
- R8: Control 0xC selects rising-edge timing. `ser_out` then changes after each rising edge, half a clock period earlier than in R7, and shows the bit sampled 15 rising edges earlier.
- R9: Control 0xA enters shutdown while `lock_n` is high. During shutdown, `shutdown` is 1 and both codes read zero, while the staging and output registers keep their contents and still accept loads.
- R10: While `lock_n` is low, control 0xA has no effect.
- R11: A high-to-low transition of `lock_n` during shutdown leaves shutdown. The codes then show the output register values from before shutdown. The same transition outside shutdown has no effect.
- R12: Control 0x0 and all control codes not listed above change no output except `ser_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial bit clock; data sampled on its rising edge |
| ser_in | input | 1 | Serial command data, MSB first |
| lock_n | input | 1 | Active-low shutdown lockout and wake input |
| ser_out | output | 1 | Shift-register output for chaining and readback |
| code_a | output | 12 | Channel A code (zero in shutdown) |
| code_b | output | 12 | Channel B code (zero in shutdown) |
| shutdown | output | 1 | High while in shutdown |
| aux_out | output | 1 | Host-programmable logic level |

## Verification
The hardest state to reach from the ports is a wake-up in which the output registers and the staging registers hold different values. That is the only case in which a correct restore can be told apart from a wrong one. The stimulus loads distinct codes and enters shutdown with `lock_n` high. It then loads a new value into one staging register while still shut down, and only after that drops `lock_n`. The expected codes are the old output values, not the newer staged value. Edge timing is checked with 32-clock frames, which the decoder ignores, so the whole first half of each frame can be watched emerging on `ser_out` in both edge modes.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  // Control field values of a command word.
  typedef enum logic [3:0] {
    CMD_NOP      = 4'h0,
    CMD_LD_A     = 4'h1,
    CMD_LD_B     = 4'h2,
    CMD_LD_BOTH  = 4'h3,
    CMD_XFER     = 4'h8,
    CMD_AUX      = 4'h9,
    CMD_SLEEP    = 4'hA,
    CMD_EDGE_FALL = 4'hB,
    CMD_EDGE_RISE = 4'hC
  } cmd_e;

  localparam int unsigned CTRL_W = 4;
  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic              rise_mode,
  output logic              sdo,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic              sck_prev, sel_prev;
  logic              sck_rise, sck_fall, sel_rise, sel_fall;
  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  assign sck_rise = sck_s & ~sck_prev & ~sel_s;
  assign sck_fall = ~sck_s & sck_prev & ~sel_s;
  assign sel_rise = sel_s & ~sel_prev;
  assign sel_fall = ~sel_s & sel_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev   <= 1'b0;
      sel_prev   <= 1'b1;
      sr_q       <= '0;
      cnt_q      <= '0;
      sdo        <= 1'b0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      sck_prev   <= sck_s;
      sel_prev   <= sel_s;
      word_valid <= 1'b0;
      if (sel_fall) cnt_q <= '0;
      if (sck_rise) begin
        sr_q <= {sr_q[WORD_W-2:0], sdi_s};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        if (rise_mode) sdo <= sr_q[WORD_W-2];
      end
      if (sck_fall && !rise_mode) sdo <= sr_q[WORD_W-1];
      if (sel_rise && cnt_q == CNT_FULL) begin
        word_valid <= 1'b1;
        word       <= sr_q;
      end
    end
  end

endmodule

// File: rtl/dacif_chan.sv
module dacif_chan #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              xfer,
  input  logic              sleep_n,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] code
);

  logic [DATA_W-1:0] stage_q, out_q, stage_n, out_n;

  always_comb begin
    stage_n = load ? data : stage_q;
    out_n   = xfer ? stage_n : out_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      out_q   <= '0;
      code    <= '0;
    end else begin
      stage_q <= stage_n;
      out_q   <= out_n;
      code    <= sleep_n ? '0 : out_n;
    end
  end

endmodule

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  localparam int unsigned WORD_W = CTRL_W + DATA_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          word_valid,
  input  logic [WORD_W-1:0]             word,
  input  logic                          lock_s,
  output logic [NUM_CH-1:0][DATA_W-1:0] codes,
  output logic                          sleep_q,
  output logic                          aux_q,
  output logic                          rise_mode_q
);

  logic              lock_prev, lock_fall;
  logic [NUM_CH-1:0] load;
  logic              xfer, sleep_n, aux_n, rise_n;
  logic [CTRL_W-1:0] ctrl;
  logic [DATA_W-1:0] payload;

  assign ctrl      = word[WORD_W-1 -: CTRL_W];
  assign payload   = word[DATA_W-1:0];
  assign lock_fall = lock_prev & ~lock_s;

  always_comb begin
    load    = '0;
    xfer    = 1'b0;
    sleep_n = sleep_q;
    aux_n   = aux_q;
    rise_n  = rise_mode_q;
    if (lock_fall && sleep_q) sleep_n = 1'b0;
    if (word_valid) begin
      case (ctrl)
        CMD_LD_A:      load[0] = 1'b1;
        CMD_LD_B:      load[1] = 1'b1;
        CMD_LD_BOTH: begin
          load = '1;
          xfer = 1'b1;
        end
        CMD_XFER:      xfer = 1'b1;
        CMD_AUX:       aux_n = payload[0];
        CMD_SLEEP:     if (lock_s) sleep_n = 1'b1;
        CMD_EDGE_FALL: rise_n = 1'b0;
        CMD_EDGE_RISE: rise_n = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_prev   <= 1'b1;
      sleep_q     <= 1'b0;
      aux_q       <= 1'b0;
      rise_mode_q <= 1'b0;
    end else begin
      lock_prev   <= lock_s;
      sleep_q     <= sleep_n;
      aux_q       <= aux_n;
      rise_mode_q <= rise_n;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dacif_chan #(.DATA_W(DATA_W)) i_chan (
      .clk     (clk),
      .rst     (rst),
      .load    (load[c]),
      .xfer    (xfer),
      .sleep_n (sleep_n),
      .data    (payload),
      .code    (codes[c])
    );
  end

endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dacif_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_in,
  input  logic              lock_n,
  output logic              ser_out,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              shutdown,
  output logic              aux_out
);

  localparam int unsigned WORD_W = CTRL_W + DATA_W;

  logic                          cs_s, sck_s, sdi_s, lock_s;
  logic                          word_valid, rise_mode;
  logic [WORD_W-1:0]             word;
  logic [NUM_CH-1:0][DATA_W-1:0] codes;

  dacif_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_sel_n, ser_clk, ser_in, lock_n}),
    .q   ({cs_s, sck_s, sdi_s, lock_s})
  );

  dacif_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk        (clk),
    .rst        (rst),
    .sel_s      (cs_s),
    .sck_s      (sck_s),
    .sdi_s      (sdi_s),
    .rise_mode  (rise_mode),
    .sdo        (ser_out),
    .word_valid (word_valid),
    .word       (word)
  );

  dacif_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .word_valid  (word_valid),
    .word        (word),
    .lock_s      (lock_s),
    .codes       (codes),
    .sleep_q     (shutdown),
    .aux_q       (aux_out),
    .rise_mode_q (rise_mode)
  );

  assign code_a = codes[0];
  assign code_b = codes[1];

endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              lock_s,
  input logic              cs_s,
  input logic              word_valid,
  input logic              shutdown,
  input logic [DATA_W-1:0] code_a,
  input logic [DATA_W-1:0] code_b,
  input logic              aux_out,
  input logic              ser_out
);

  logic [1:0] arm_q;
  logic       armed;

  always_ff @(posedge clk) begin
    if (rst) arm_q <= '0;
    else if (arm_q != 2'd3) arm_q <= arm_q + 2'd1;
  end
  assign armed = (arm_q == 2'd3);

  // R9
  shdn_zero_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    shutdown |-> (code_a == '0 && code_b == '0));

  // R10
  shdn_lock_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(shutdown) |-> $past(lock_s));

  // R11
  wake_edge_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(shutdown) |-> ($past(lock_s, 2) && !$past(lock_s)));

  // R2
  code_cause_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$stable(code_a) || !$stable(code_b)) |-> ($past(word_valid) || !$stable(shutdown)));

  // R6
  aux_cause_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(aux_out) |-> $past(word_valid));

  // R7
  sdo_frame_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(ser_out) |-> !$past(cs_s));

endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .lock_s     (lock_s),
  .cs_s       (cs_s),
  .word_valid (word_valid),
  .shutdown   (shutdown),
  .code_a     (code_a),
  .code_b     (code_b),
  .aux_out    (aux_out),
  .ser_out    (ser_out)
);

// File: tb/test_dual_dac_ctrl.sv
`timescale 1ns/1ps
module test_dual_dac_ctrl;

  localparam int HALF = 8;   // system clocks per serial half period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_sel_n = 1'b1, ser_clk = 1'b0, ser_in = 1'b0, lock_n = 1'b1;
  logic ser_out, shutdown, aux_out;
  logic [11:0] code_a, code_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  dual_dac_ctrl i_dual_dac_ctrl (
    .clk(clk), .rst(rst), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_in(ser_in), .lock_n(lock_n), .ser_out(ser_out), .code_a(code_a),
    .code_b(code_b), .shutdown(shutdown), .aux_out(aux_out)
  );

  typedef struct packed {
    logic [15:0] word;
    logic [11:0] ea;
    logic [11:0] eb;
    logic        eu;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'h1ABC, 12'h000, 12'h000, 1'b0, 8'd3},   // R3
    '{16'h2123, 12'h000, 12'h000, 1'b0, 8'd3},   // R3
    '{16'h8000, 12'hABC, 12'h123, 1'b0, 8'd5},   // R5
    '{16'h35A5, 12'h5A5, 12'h5A5, 1'b0, 8'd4},   // R4
    '{16'h9001, 12'h5A5, 12'h5A5, 1'b1, 8'd6},   // R6
    '{16'h0FFF, 12'h5A5, 12'h5A5, 1'b1, 8'd12},  // R12
    '{16'h7FFF, 12'h5A5, 12'h5A5, 1'b1, 8'd12},  // R12
    '{16'h9FFE, 12'h5A5, 12'h5A5, 1'b0, 8'd6},   // R6
    '{16'h100F, 12'h5A5, 12'h5A5, 1'b0, 8'd3},   // R3
    '{16'h8000, 12'h00F, 12'h5A5, 1'b0, 8'd5}    // R5
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends the n low bits of data, MSB first. With chk set, compares ser_out
  // with a bench model of two chained stages: the bit seen by the next stage
  // at rising edge i is the one sampled here at rising edge i-16.
  task automatic frame(input logic [31:0] data, input int n, input bit chk_out, input bit rise_m, input string req);
    @(negedge clk);
    ser_sel_n = 1'b0;
    wait_clks(HALF);
    for (int i = 0; i < n; i++) begin
      ser_in = data[n-1-i];
      wait_clks(HALF);
      if (chk_out && i >= 17)
        chk(req, "ser_out low phase", {31'd0, ser_out}, {31'd0, data[n-1-(i-16)]});
      ser_clk = 1'b1;
      wait_clks(HALF);
      if (chk_out && i >= 16)
        chk(req, "ser_out high phase", {31'd0, ser_out},
            {31'd0, rise_m ? data[n-1-(i-15)] : data[n-1-(i-16)]});
      ser_clk = 1'b0;
    end
    wait_clks(HALF);
    ser_sel_n = 1'b1;
    wait_clks(12);
  endtask

  task automatic cmd(input logic [15:0] w);
    frame({16'd0, w}, 16, 1'b0, 1'b0, "");
  endtask

  task automatic chk_state(input string req, input logic [11:0] ea, input logic [11:0] eb, input logic eu, input logic es);
    chk(req, "code_a", {20'd0, code_a}, {20'd0, ea});
    chk(req, "code_b", {20'd0, code_b}, {20'd0, eb});
    chk(req, "aux_out", {31'd0, aux_out}, {31'd0, eu});
    chk(req, "shutdown", {31'd0, shutdown}, {31'd0, es});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    wait_clks(6);
    rst = 1'b0;
    wait_clks(4);
    // R1 reset defaults
    chk_state("R1", 12'h000, 12'h000, 1'b0, 1'b0);
    chk("R1", "ser_out", {31'd0, ser_out}, 32'd0);

    // main table
    for (int v = 0; v < NV; v++) begin
      cmd(VECS[v].word);
      chk_state($sformatf("R%0d", VECS[v].req), VECS[v].ea, VECS[v].eb, VECS[v].eu, 1'b0);
    end

    // R2 wrong clock counts are ignored
    frame(32'h0000_1BBB, 15, 1'b0, 1'b0, "R2");
    chk_state("R2", 12'h00F, 12'h5A5, 1'b0, 1'b0);
    frame(32'h0000_6EEE, 17, 1'b0, 1'b0, "R2");
    chk_state("R2", 12'h00F, 12'h5A5, 1'b0, 1'b0);

    // R7 falling-edge timing (default), 32-clock frame also ignored (R2)
    frame(32'hC3A5_5A3C, 32, 1'b1, 1'b0, "R7");
    chk_state("R2", 12'h00F, 12'h5A5, 1'b0, 1'b0);
    // R8 rising-edge timing
    cmd(16'hC000);
    frame(32'h96E1_3B47, 32, 1'b1, 1'b1, "R8");
    // back to falling-edge timing
    cmd(16'hB000);
    frame(32'h0F0F_1234, 32, 1'b1, 1'b0, "R7");
    chk_state("R2", 12'h00F, 12'h5A5, 1'b0, 1'b0);

    // R10 shutdown ignored under lockout
    lock_n = 1'b0;
    wait_clks(8);
    cmd(16'hA000);
    chk_state("R10", 12'h00F, 12'h5A5, 1'b0, 1'b0);
    lock_n = 1'b1;
    wait_clks(8);
    chk_state("R11", 12'h00F, 12'h5A5, 1'b0, 1'b0);

    // R9 shutdown accepted, loads still taken
    cmd(16'hA000);
    chk_state("R9", 12'h000, 12'h000, 1'b0, 1'b1);
    cmd(16'h1321);
    chk_state("R9", 12'h000, 12'h000, 1'b0, 1'b1);

    // R11 lockout fall wakes with pre-shutdown codes
    lock_n = 1'b0;
    wait_clks(8);
    chk_state("R11", 12'h00F, 12'h5A5, 1'b0, 1'b0);
    cmd(16'h8000);
    chk_state("R9", 12'h321, 12'h5A5, 1'b0, 1'b0);
    lock_n = 1'b1;
    wait_clks(8);
    lock_n = 1'b0;
    wait_clks(8);
    chk_state("R11", 12'h321, 12'h5A5, 1'b0, 1'b0);
    lock_n = 1'b1;
    wait_clks(8);

    // R1 reset again from rising-edge mode with aux set
    cmd(16'hC000);
    cmd(16'h9001);
    @(negedge clk);
    rst = 1'b1;
    wait_clks(4);
    rst = 1'b0;
    wait_clks(4);
    chk_state("R1", 12'h000, 12'h000, 1'b0, 1'b0);
    chk("R1", "ser_out", {31'd0, ser_out}, 32'd0);
    frame(32'h5AC3_E817, 32, 1'b1, 1'b0, "R1");

    finish_run();
  end

endmodule